// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block is the receiving end of a serial configuration link. It connects to an external one-bit-wide configuration memory. A start pulse begins each load. The loader pulls its memory-reset line low for a fixed number of system clocks, so the memory's address counter returns to zero before every load, including a reload requested in the middle of a transfer. It then releases that line and produces a configuration clock by dividing the system clock by an even ratio. On each rising edge of the configuration clock it captures one bit from the memory's data line.

Captured bits are packed most-significant-first into words, and each word appears with a one-cycle valid pulse. When the bit count reaches the parameterised bitstream length, the loader raises its done line. That line drives the memory's active-low chip enable, so raising it puts the memory in standby and stops its address counter. The configuration clock runs for exactly one more period and then stays low. Only at that point does the io_active output rise, which gives the early-done ordering: the memory's output is disabled one configuration clock period before user I/O is enabled.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, init_n, done, io_active, cfg_clk and word_valid are all low, and they stay low until start is pulsed.
- R2: A start pulse seen at a clock edge drives init_n low from the next cycle for exactly INIT_CYCLES cycles. done is low during that time and cfg_clk is held low.
- R3: While loading, cfg_clk is clk divided by CLK_RATIO. Each period is CLK_RATIO/2 cycles low followed by CLK_RATIO/2 cycles high, and the first period begins low in the first cycle after init_n rises.
- R4: ser_din is captured at the clk edge on which cfg_clk rises. The first captured bit goes to word_data bit WORD_W-1, and each later bit takes the next lower position. A full word is presented with word_valid high for exactly one cycle.
- R5: When BIT_COUNT is not a multiple of WORD_W, the bits left over at the end are emitted as one final word. They sit in the top positions and the unused low bits are zero.
- R6: While done is low, cfg_clk produces exactly BIT_COUNT rising edges. done rises at the edge that captures the last bit.
- R7: io_active rises exactly CLK_RATIO clk cycles after done rises. During that interval cfg_clk completes one full period, high first and then low.
- R8: Once io_active is high, cfg_clk stays low, no word is emitted, and done and io_active stay high until the next start.
- R9: A start pulse during a load abandons it: init_n falls in the next cycle, partial words are discarded, and a complete new load follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins or restarts a load |
| ser_din | input | 1 | Serial data from the configuration memory |
| cfg_clk | output | 1 | Divided configuration clock to the memory |
| init_n | output | 1 | Active-low hold of the memory's address counter |
| done | output | 1 | High when the load has finished; drives the memory's active-low chip enable |
| io_active | output | 1 | High when user I/O may be enabled |
| word_data | output | WORD_W | Packed received word, first bit in the MSB |
| word_valid | output | 1 | One-cycle strobe for word_data |

## Verification
The properties assume that start is synchronous to clk and lasts a single cycle. They also assume that ser_din comes from a memory that advances only on rising cfg_clk edges while done is low and that returns to address zero whenever init_n is low. The bench's memory model works exactly that way. It updates its address and data on falling clk edges, uses the done level it saw one edge earlier as its chip enable, and pulses start for one cycle away from the active edge. Two pattern seeds and an aborted load exercise the restart path, and a bit length that is not a multiple of the word width exercises the final partial word.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_INIT    = 3'd1,
        ST_LOAD    = 3'd2,
        ST_EARLY   = 3'd3,
        ST_RELEASE = 3'd4
    } ld_state_e;

endpackage

// File: rtl/cfg_clk_div.sv
module cfg_clk_div #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic cfg_clk,
    output logic rise_next
);
    localparam int HALF = RATIO / 2;
    localparam int CW   = (RATIO > 2) ? $clog2(RATIO) : 1;

    typedef struct packed {
        logic [CW-1:0] phase;
    } div_t;

    div_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!run) begin
            nxt_d.phase = '0;
        end else if (cur_q.phase == CW'(RATIO - 1)) begin
            nxt_d.phase = '0;
        end else begin
            nxt_d.phase = cur_q.phase + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // High half of the period is the upper half of the phase range
    assign cfg_clk   = run && (cur_q.phase >= CW'(HALF));
    // The next edge is the one on which cfg_clk rises
    assign rise_next = run && (cur_q.phase == CW'(HALF - 1));

endmodule

// File: rtl/cfg_word_pack.sv
module cfg_word_pack #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              last,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic              valid
);
    localparam int CW = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] word;
        logic              valid;
    } pack_t;

    pack_t cur_q, nxt_d;
    logic [WORD_W-1:0] merged;
    logic [CW-1:0]     pad;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        merged      = {cur_q.sr[WORD_W-2:0], din};
        pad         = CW'(WORD_W - 1) - cur_q.cnt;
        if (clear) begin
            nxt_d.sr  = '0;
            nxt_d.cnt = '0;
        end else if (shift) begin
            if (last || (cur_q.cnt == CW'(WORD_W - 1))) begin
                // Left-align whatever has been collected, zero below
                nxt_d.word  = merged << pad;
                nxt_d.valid = 1'b1;
                nxt_d.sr    = '0;
                nxt_d.cnt   = '0;
            end else begin
                nxt_d.sr  = merged;
                nxt_d.cnt = cur_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign word  = cur_q.word;
    assign valid = cur_q.valid;

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
    import cfg_loader_pkg::*;
#(
    parameter int INIT_CYCLES = 16,
    parameter int BIT_COUNT   = 197696
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rise_next,
    output logic run,
    output logic init_n,
    output logic done,
    output logic io_active,
    output logic shift,
    output logic last
);
    localparam int IW = $clog2(INIT_CYCLES + 1);
    localparam int BW = $clog2(BIT_COUNT + 1);

    typedef struct packed {
        ld_state_e     st;
        logic [IW-1:0] icnt;
        logic [BW-1:0] bcnt;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_IDLE: ;
            ST_INIT: begin
                if (cur_q.icnt == IW'(INIT_CYCLES - 1)) begin
                    nxt_d.st   = ST_LOAD;
                    nxt_d.bcnt = '0;
                end else begin
                    nxt_d.icnt = cur_q.icnt + IW'(1);
                end
            end
            ST_LOAD: begin
                if (rise_next) begin
                    nxt_d.bcnt = cur_q.bcnt + BW'(1);
                    if (cur_q.bcnt == BW'(BIT_COUNT - 1)) nxt_d.st = ST_EARLY;
                end
            end
            ST_EARLY: begin
                // One more full configuration clock period before release
                if (rise_next) nxt_d.st = ST_RELEASE;
            end
            ST_RELEASE: ;
            default: nxt_d.st = ST_IDLE;
        endcase
        if (start) begin
            nxt_d.st   = ST_INIT;
            nxt_d.icnt = '0;
            nxt_d.bcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_IDLE, icnt: '0, bcnt: '0};
        else        cur_q <= nxt_d;
    end

    assign run       = (cur_q.st == ST_LOAD) || (cur_q.st == ST_EARLY);
    assign init_n    = (cur_q.st != ST_IDLE) && (cur_q.st != ST_INIT);
    assign done      = (cur_q.st == ST_EARLY) || (cur_q.st == ST_RELEASE);
    assign io_active = (cur_q.st == ST_RELEASE);
    assign shift     = (cur_q.st == ST_LOAD) && rise_next;
    assign last      = shift && (cur_q.bcnt == BW'(BIT_COUNT - 1));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
    parameter int CLK_RATIO   = 4,
    parameter int INIT_CYCLES = 16,
    parameter int BIT_COUNT   = 197696,
    parameter int WORD_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ser_din,
    output logic              cfg_clk,
    output logic              init_n,
    output logic              done,
    output logic              io_active,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid
);
    logic run;
    logic rise_next;
    logic shift;
    logic last;

    cfg_load_seq #(
        .INIT_CYCLES (INIT_CYCLES),
        .BIT_COUNT   (BIT_COUNT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rise_next (rise_next),
        .run       (run),
        .init_n    (init_n),
        .done      (done),
        .io_active (io_active),
        .shift     (shift),
        .last      (last)
    );

    cfg_clk_div #(
        .RATIO (CLK_RATIO)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cfg_clk   (cfg_clk),
        .rise_next (rise_next)
    );

    cfg_word_pack #(
        .WORD_W (WORD_W)
    ) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .shift (shift),
        .last  (last),
        .din   (ser_din),
        .word  (word_data),
        .valid (word_valid)
    );

endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk #(
    parameter int CLK_RATIO = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic cfg_clk,
    input logic init_n,
    input logic done,
    input logic io_active,
    input logic word_valid
);
    localparam int AW = $clog2(CLK_RATIO + 2);

    // Cycles since done went high, saturating
    logic [AW-1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          age_q <= '0;
        else if (!done)                      age_q <= '0;
        else if (age_q != AW'(CLK_RATIO + 1)) age_q <= age_q + AW'(1);
    end

    a_r2_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |-> (!done && !cfg_clk));

    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r7_release_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_active) |-> (age_q == AW'(CLK_RATIO)));

    a_r8_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (io_active && !start) |=> (io_active && done && !cfg_clk && !word_valid));

    a_r8_io_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        io_active |-> done);

endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(
    .CLK_RATIO (CLK_RATIO)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_clk    (cfg_clk),
    .init_n     (init_n),
    .done       (done),
    .io_active  (io_active),
    .word_valid (word_valid)
);

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
    localparam int P_RATIO = 4;
    localparam int P_HALF  = P_RATIO / 2;
    localparam int P_INIT  = 5;
    localparam int P_BITS  = 44;
    localparam int P_W     = 8;
    localparam int NWORDS  = (P_BITS + P_W - 1) / P_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ser_din = 1'b0;
    logic cfg_clk, init_n, done, io_active, word_valid;
    logic [P_W-1:0] word_data;

    int n_checks = 0;
    int n_fail = 0;
    int mem_addr = 0;
    int seed = 1;
    int word_idx = 0;
    bit ignore_words = 1'b1;
    bit finished = 1'b0;
    logic cfg_prev = 1'b0;
    logic done_seen = 1'b0;
    logic [P_W-1:0] exp_q[$];

    always #5 clk = ~clk;

    cfg_serial_loader #(
        .CLK_RATIO   (P_RATIO),
        .INIT_CYCLES (P_INIT),
        .BIT_COUNT   (P_BITS),
        .WORD_W      (P_W)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .ser_din    (ser_din),
        .cfg_clk    (cfg_clk),
        .init_n     (init_n),
        .done       (done),
        .io_active  (io_active),
        .word_data  (word_data),
        .word_valid (word_valid)
    );

    function automatic logic pat(int a, int s);
        return 1'((((a * 29 + s) / 3) + (a / 7)) % 2);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Serial memory model: address advances on a cfg_clk rise while enabled
    always @(negedge clk) begin
        if (!init_n) mem_addr = 0;
        else if (cfg_clk && !cfg_prev && !done_seen) mem_addr++;
        cfg_prev  = cfg_clk;
        done_seen = done;
        ser_din   = done ? 1'b1 : pat(mem_addr, seed);
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && word_valid && !ignore_words) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected word", int'(word_data), -1);
            end else begin
                logic [P_W-1:0] e;
                e = exp_q.pop_front();
                check(word_data == e, (word_idx == NWORDS - 1) ? "R5" : "R4",
                      "word value", int'(word_data), int'(e));
                word_idx++;
            end
        end
    end

    task automatic push_expected(int s);
        for (int w = 0; w < NWORDS; w++) begin
            logic [P_W-1:0] v;
            v = '0;
            for (int b = 0; b < P_W; b++) begin
                if (w * P_W + b < P_BITS) v[P_W-1-b] = pat(w * P_W + b, s);
            end
            exp_q.push_back(v);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic do_load(int s, bit abort_first);
        int n;
        int h;
        if (abort_first) begin
            ignore_words = 1'b1;
            seed = s + 100;
            pulse_start();
            while (!init_n) step();
            repeat (40) step();
            check(mem_addr == (40 - P_HALF) / P_RATIO + 1, "R9", "edges before abort",
                  mem_addr, (40 - P_HALF) / P_RATIO + 1);
        end
        seed = s;
        word_idx = 0;
        push_expected(s);
        pulse_start();
        ignore_words = 1'b0;
        check(init_n == 1'b0, "R9", "init_n low after start", int'(init_n), 0);
        check(mem_addr == 0, "R9", "memory address reset", mem_addr, 0);
        check(done == 1'b0, "R2", "done low in init", int'(done), 0);
        n = 0;
        while (!init_n) begin
            if (cfg_clk) check(1'b0, "R2", "cfg_clk during init", 1, 0);
            n++;
            step();
        end
        check(n == P_INIT, "R2", "init_n low cycles", n, P_INIT);
        n = 0;
        while (!cfg_clk) begin n++; step(); end
        check(n == P_HALF, "R3", "first low phase", n, P_HALF);
        n = 0;
        while (cfg_clk) begin n++; step(); end
        check(n == P_HALF, "R3", "first high phase", n, P_HALF);
        while (!done) begin
            if (!init_n) check(1'b0, "R9", "init_n dropped in load", 0, 1);
            step();
        end
        check(mem_addr == P_BITS, "R6", "cfg_clk rises while enabled", mem_addr, P_BITS);
        n = 0;
        h = 0;
        while (!io_active) begin
            if (cfg_clk) h++;
            n++;
            step();
        end
        check(n == P_RATIO, "R7", "done to io_active cycles", n, P_RATIO);
        check(h == P_HALF, "R7", "high cycles after done", h, P_HALF);
        h = 0;
        repeat (20) begin
            if (cfg_clk) h++;
            step();
        end
        check(h == 0, "R8", "cfg_clk high after release", h, 0);
        check(done && io_active, "R8", "done and io_active held", int'(done && io_active), 1);
        check(mem_addr == P_BITS, "R8", "memory address frozen", mem_addr, P_BITS);
        check(word_idx == NWORDS, "R5", "words delivered", word_idx, NWORDS);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        check(!init_n && !done && !io_active && !cfg_clk && !word_valid, "R1",
              "outputs in reset", int'({init_n, done, io_active, cfg_clk, word_valid}), 0);
        rst_n = 1'b1;
        repeat (6) step();
        check(!init_n && !done && !io_active && !cfg_clk && !word_valid, "R1",
              "idle after reset", int'({init_n, done, io_active, cfg_clk, word_valid}), 0);
        do_load(1, 1'b0);
        do_load(5, 1'b0);
        do_load(9, 1'b1);
        check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule